// File: doc/BRIEF.md
# Dual-Mode Host Register Access Unit

This block sits between a host processor bus and the register space of a multi-channel serial controller. The host runs read, write and interrupt-acknowledge cycles with active-low chip-enable, read, write and interrupt-acknowledge strobes. The block brings those strobes into the local clock domain and decodes them. It answers each cycle with an active-low data-acknowledge, commits writes to a small register file and returns read data with an output-enable for the shared data bus.

Two timing modes are supported. In handshake mode the host waits for the acknowledge. A write then lands at the acknowledge, or at the end of the strobe if that comes first. In strobe-timed mode the host relies on minimum strobe widths, and a write lands only when the strobe ends. A control bit can disable the acknowledge altogether.

An interrupt-acknowledge cycle captures the pending interrupt's channel and priority into a snapshot register and drives an interrupt vector onto the bus. Hosts without that strobe can take the same snapshot with a command write. The interrupt request output never loads the snapshot.

Top module: `hostbus_if`

## Requirements
- R1: After reset, dack_n and irq_n are high, data_oe is low, the control register at 0x20 reads 0x01 (bit 0 acknowledge enable = 1, bit 1 mode = 0 handshake), and the snapshot register at 0x2B reads 0x00.
- R2: With the acknowledge enabled, dack_n goes low at the fourth rising clock edge after the strobes of a read, write or interrupt-acknowledge cycle are asserted. That is two synchronizer stages and then two edges of the cycle. dack_n returns high once the cycle's strobes are released.
- R3: With control bit 0 cleared, dack_n stays high through every kind of cycle.
- R4: In handshake mode with the acknowledge enabled, a write commits once, at the edge where the acknowledge asserts. A data change later in the same strobe is not stored.
- R5: In handshake mode with the acknowledge disabled, and in any cycle whose strobe ends before the acknowledge, the write commits when the combined chip-enable and write strobe ends. The data it stores is the last value seen while the strobe was active.
- R6: In strobe-timed mode (control bit 1 set), a write commits only at the end of the combined strobe and stores the final data, even when the acknowledge asserted earlier.
- R7: Registers 0x00 to 0x0F read back the value last written. During a read, data_oe is high and data_o holds the addressed register.
- R8: A read ends when either chip-enable or read strobe rises first. data_oe falls within four clock edges of that rise.
- R9: An interrupt-acknowledge cycle loads the snapshot register with {2'b00, pend_pri[2:0], pend_src[2:0]}. It drives data_o = {vector[7:3], pend_src} with data_oe high. Pending-input changes later in the cycle alter neither.
- R10: A write of any data to command address 0x2A loads the snapshot register from the pending inputs, with no acknowledge cycle involved.
- R11: irq_n is the registered inverse of pend_valid. Changes on pend_valid, pend_src and pend_pri never alter the snapshot register without an acknowledge cycle or command.
- R12: data_oe is low when no read or interrupt-acknowledge cycle is active, including throughout write cycles.
- R13: The vector register at 0x2C is readable and writable. Writes to 0x2B and to unmapped addresses leave readable state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip-enable strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| iack_n | input | 1 | Interrupt-acknowledge strobe, active low |
| addr | input | ADDR_W (6) | Register address |
| data_i | input | DATA_W (8) | Write data from host |
| data_o | output | DATA_W (8) | Read data or interrupt vector |
| data_oe | output | 1 | Data bus drive enable (high-impedance when low) |
| dack_n | output | 1 | Data-acknowledge, active low |
| irq_n | output | 1 | Interrupt request, active low |
| pend_valid | input | 1 | An interrupt is pending |
| pend_src | input | 3 | Channel of the pending interrupt |
| pend_pri | input | 3 | Priority of the pending interrupt |

## Verification
The bench holds a write strobe past the acknowledge and then changes the data. A design that commits at the wrong moment in either mode stores the wrong one of the two values, and one that commits twice overwrites the first value in handshake mode. It releases only chip-enable or only the read strobe to catch a read that waits for both to rise. It moves the pending inputs and pend_valid without any acknowledge, which exposes a snapshot loaded from the interrupt request. It counts the edges to the acknowledge, where an off-by-one in the synchronizer or the counter shows up directly. Randomized writes with short strobes, random modes and acknowledge settings, followed by read-back, catch a write that is lost when the strobe ends before the acknowledge.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  localparam int HB_CTRL_ADDR = 'h20;
  localparam int HB_CMD_ADDR  = 'h2A;
  localparam int HB_SNAP_ADDR = 'h2B;
  localparam int HB_VEC_ADDR  = 'h2C;

  typedef enum logic {
    MODE_HANDSHAKE = 1'b0,
    MODE_STROBE    = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic [2:0] pri;
    logic [2:0] src;
  } snap_t;
endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_cycle_ctl.sv
`timescale 1ns/1ps
module hb_cycle_ctl
  import hb_pkg::*;
#(
  parameter int ACK_DLY = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      s_ce,
  input  logic      s_rd,
  input  logic      s_wr,
  input  logic      s_iack,
  input  logic      ack_en,
  input  bus_mode_e mode,
  output logic      dack,
  output logic      commit,
  output logic      rd_act,
  output logic      iack_act,
  output logic      iack_rise
);
  localparam int CW = $clog2(ACK_DLY + 1);

  logic          cyc, wcyc, w_prev, done, iack_prev, ack_evt, w_fall;
  logic [CW-1:0] cnt;

  assign cyc       = (s_ce & (s_rd | s_wr)) | s_iack;
  assign wcyc      = s_ce & s_wr;
  assign rd_act    = s_ce & s_rd;
  assign iack_act  = s_iack;
  assign iack_rise = s_iack & ~iack_prev;
  assign w_fall    = w_prev & ~wcyc;
  assign ack_evt   = ack_en & wcyc & ~dack & (cnt == CW'(ACK_DLY - 1));
  assign commit    = ~done & (w_fall | ((mode == MODE_HANDSHAKE) & ack_evt));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      dack      <= 1'b0;
      w_prev    <= 1'b0;
      done      <= 1'b0;
      iack_prev <= 1'b0;
    end else begin
      w_prev    <= wcyc;
      iack_prev <= s_iack;
      if (!cyc)                    cnt <= '0;
      else if (cnt < CW'(ACK_DLY)) cnt <= cnt + 1'b1;
      dack <= ack_en & cyc & (dack | (cnt == CW'(ACK_DLY - 1)));
      done <= wcyc & (done | commit);
    end
  end

  AST_ACK_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dack |-> $past(cyc)); // R2
  AST_ACK_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !ack_en |=> !dack); // R3
  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit); // R4
  AST_STROBE_MODE_AT_END: assert property (@(posedge clk) disable iff (rst)
    (commit && mode == MODE_STROBE) |-> (!wcyc && w_prev)); // R6
endmodule

// File: rtl/hb_regs.sv
`timescale 1ns/1ps
module hb_regs
  import hb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int NREG   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              rd_act,
  input  logic              iack_act,
  input  logic              iack_rise,
  input  logic [2:0]        pend_src,
  input  logic [2:0]        pend_pri,
  output logic              ack_en,
  output bus_mode_e         mode,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe
);
  localparam int IDX_W = $clog2(NREG);

  logic [DATA_W-1:0] ram [NREG];
  logic [DATA_W-1:0] ram_q, vec_q, rd_mux;
  snap_t             snap_q;
  logic              snap_load, w_ram;

  assign w_ram     = commit & (waddr < ADDR_W'(NREG));
  assign snap_load = iack_rise | (commit & (waddr == ADDR_W'(HB_CMD_ADDR)));

  always_ff @(posedge clk) begin
    if (w_ram) ram[waddr[IDX_W-1:0]] <= wdata;
    ram_q <= ram[raddr[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_en <= 1'b1;
      mode   <= MODE_HANDSHAKE;
      vec_q  <= '0;
      snap_q <= '0;
    end else begin
      if (commit && waddr == ADDR_W'(HB_CTRL_ADDR)) begin
        ack_en <= wdata[0];
        mode   <= bus_mode_e'(wdata[1]);
      end
      if (commit && waddr == ADDR_W'(HB_VEC_ADDR)) vec_q <= wdata;
      if (snap_load) snap_q <= '{pri: pend_pri, src: pend_src};
    end
  end

  always_comb begin
    rd_mux = '0;
    if (raddr < ADDR_W'(NREG))               rd_mux = ram_q;
    else if (raddr == ADDR_W'(HB_CTRL_ADDR)) rd_mux = DATA_W'({mode, ack_en});
    else if (raddr == ADDR_W'(HB_SNAP_ADDR)) rd_mux = DATA_W'(snap_q);
    else if (raddr == ADDR_W'(HB_VEC_ADDR))  rd_mux = vec_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      data_oe <= 1'b0;
    end else begin
      data_oe <= rd_act | iack_act;
      if (iack_act)
        data_o <= {vec_q[DATA_W-1:3], (iack_rise ? pend_src : snap_q.src)};
      else if (rd_act)
        data_o <= rd_mux;
      else
        data_o <= '0;
    end
  end

  AST_SNAP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$stable(snap_q) |-> $past(snap_load)); // R11
  AST_OE_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(rd_act | iack_act)); // R12
endmodule

// File: rtl/hostbus_if.sv
`timescale 1ns/1ps
module hostbus_if
  import hb_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int NREG        = 16,
  parameter int ACK_DLY     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              iack_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              dack_n,
  output logic              irq_n,
  input  logic              pend_valid,
  input  logic [2:0]        pend_src,
  input  logic [2:0]        pend_pri
);
  logic [3:0]        s_strb;
  logic [ADDR_W-1:0] waddr_q, raddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              dack, commit, rd_act, iack_act, iack_rise, ack_en, irq_q;
  bus_mode_e         mode;

  hb_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({~ce_n, ~rd_n, ~wr_n, ~iack_n}),
    .q   (s_strb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr_q <= '0;
      wdata_q <= '0;
      raddr_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= pend_valid;
      if (!ce_n && !wr_n) begin
        waddr_q <= addr;
        wdata_q <= data_i;
      end
      if (!ce_n && !rd_n) raddr_q <= addr;
    end
  end

  hb_cycle_ctl #(.ACK_DLY(ACK_DLY)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .s_ce      (s_strb[3]),
    .s_rd      (s_strb[2]),
    .s_wr      (s_strb[1]),
    .s_iack    (s_strb[0]),
    .ack_en    (ack_en),
    .mode      (mode),
    .dack      (dack),
    .commit    (commit),
    .rd_act    (rd_act),
    .iack_act  (iack_act),
    .iack_rise (iack_rise)
  );

  hb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit),
    .waddr     (waddr_q),
    .wdata     (wdata_q),
    .raddr     (raddr_q),
    .rd_act    (rd_act),
    .iack_act  (iack_act),
    .iack_rise (iack_rise),
    .pend_src  (pend_src),
    .pend_pri  (pend_pri),
    .ack_en    (ack_en),
    .mode      (mode),
    .data_o    (data_o),
    .data_oe   (data_oe)
  );

  assign dack_n = ~dack;
  assign irq_n  = ~irq_q;

  AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_n == !$past(pend_valid)); // R11
  AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (s_strb[1] && !s_strb[2] && !s_strb[0] && $past(s_strb[1] && !s_strb[2] && !s_strb[0])) |-> !data_oe); // R12
endmodule

// File: tb/tb_hostbus_if.sv
`timescale 1ns/1ps
module tb_hostbus_if;
  localparam int CYC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, iack_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       data_oe, dack_n, irq_n;
  logic       pend_valid = 1'b0;
  logic [2:0] pend_src = '0, pend_pri = '0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [16];
  logic [7:0] m_vec = 8'h00;
  logic [7:0] m_snap = 8'h00;

  always #(CYC/2) clk = ~clk;

  hostbus_if dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n), .iack_n(iack_n),
    .addr(addr), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
    .dack_n(dack_n), .irq_n(irq_n), .pend_valid(pend_valid),
    .pend_src(pend_src), .pend_pri(pend_pri)
  );

  function automatic logic [7:0] f_snap(input logic [2:0] pri, input logic [2:0] src);
    return {2'b00, pri, src};
  endfunction

  function automatic logic [7:0] f_vec(input logic [7:0] v, input logic [2:0] src);
    return {v[7:3], src};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    addr = a; data_i = d; ce_n = 1'b0; wr_n = 1'b0;
    idle(hold);
    ce_n = 1'b1; wr_n = 1'b1;
    idle(5);
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; rd_n = 1'b0;
    idle(6);
    d = data_o; oe = data_oe;
    ce_n = 1'b1; rd_n = 1'b1;
    idle(5);
  endtask

  task automatic read_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic oe;
    bus_read(a, d, oe);
    chk(req, {31'd0, oe}, 32'd1);
    chk(req, {24'd0, d}, {24'd0, exp});
  endtask

  initial begin
    #(CYC * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic oe;
    int n;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 dack_n", {31'd0, dack_n}, 32'd1);
    chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
    chk("R1 data_oe", {31'd0, data_oe}, 32'd0);
    read_chk("R1 ctrl", 6'h20, 8'h01);
    read_chk("R1 snap", 6'h2B, 8'h00);

    // R2 acknowledge timing on a read
    @(negedge clk);
    addr = 6'h20; ce_n = 1'b0; rd_n = 1'b0;
    n = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (!dack_n && n == 0) n = k;
    end
    chk("R2 ack edge count", n, 4);
    ce_n = 1'b1; rd_n = 1'b1;
    idle(4);
    chk("R2 ack release", {31'd0, dack_n}, 32'd1);

    // R12 no drive during a write, R4 handshake commits at acknowledge
    @(negedge clk);
    addr = 6'h03; data_i = 8'hA5; ce_n = 1'b0; wr_n = 1'b0;
    idle(6);
    chk("R12 oe in write", {31'd0, data_oe}, 32'd0);
    chk("R2 ack in write", {31'd0, dack_n}, 32'd0);
    data_i = 8'h5A;
    idle(3);
    ce_n = 1'b1; wr_n = 1'b1;
    idle(5);
    model[3] = 8'hA5;
    read_chk("R4 first value kept", 6'h03, 8'hA5);

    // R5 handshake with acknowledge disabled commits at strobe end
    bus_write(6'h20, 8'h00, 6);
    @(negedge clk);
    addr = 6'h04; data_i = 8'h11; ce_n = 1'b0; wr_n = 1'b0;
    idle(6);
    chk("R3 ack off write", {31'd0, dack_n}, 32'd1);
    data_i = 8'h22;
    idle(3);
    ce_n = 1'b1; wr_n = 1'b1;
    idle(5);
    model[4] = 8'h22;
    @(negedge clk);
    addr = 6'h04; ce_n = 1'b0; rd_n = 1'b0;
    idle(6);
    chk("R3 ack off read", {31'd0, dack_n}, 32'd1);
    chk("R5 final value", {24'd0, data_o}, 32'h22);
    ce_n = 1'b1; rd_n = 1'b1;
    idle(5);

    // R6 strobe-timed mode with acknowledge enabled
    bus_write(6'h20, 8'h03, 3);
    read_chk("R6 ctrl", 6'h20, 8'h03);
    @(negedge clk);
    addr = 6'h05; data_i = 8'h33; ce_n = 1'b0; wr_n = 1'b0;
    idle(6);
    chk("R6 ack asserted", {31'd0, dack_n}, 32'd0);
    data_i = 8'h44;
    idle(3);
    ce_n = 1'b1; wr_n = 1'b1;
    idle(5);
    model[5] = 8'h44;
    read_chk("R6 final value", 6'h05, 8'h44);
    bus_write(6'h20, 8'h01, 6);

    // R8 read ends on first rise of either strobe
    @(negedge clk);
    addr = 6'h03; ce_n = 1'b0; rd_n = 1'b0;
    idle(6);
    chk("R8 oe on", {31'd0, data_oe}, 32'd1);
    rd_n = 1'b1;
    idle(4);
    chk("R8 rd rise", {31'd0, data_oe}, 32'd0);
    ce_n = 1'b1;
    idle(3);
    @(negedge clk);
    ce_n = 1'b0; rd_n = 1'b0;
    idle(6);
    ce_n = 1'b1;
    idle(4);
    chk("R8 ce rise", {31'd0, data_oe}, 32'd0);
    rd_n = 1'b1;
    idle(3);

    // R13 vector register and ignored writes
    bus_write(6'h2C, 8'hC8, 6);
    m_vec = 8'hC8;
    read_chk("R13 vector", 6'h2C, 8'hC8);
    bus_write(6'h2B, 8'hFF, 6);
    bus_write(6'h3E, 8'hFF, 6);
    read_chk("R13 snap unchanged", 6'h2B, 8'h00);
    read_chk("R13 ctrl unchanged", 6'h20, 8'h01);

    // R11 irq follows pending, snapshot untouched
    pend_valid = 1'b1; pend_src = 3'd5; pend_pri = 3'd6;
    idle(2);
    chk("R11 irq low", {31'd0, irq_n}, 32'd0);
    read_chk("R11 snap not loaded", 6'h2B, 8'h00);

    // R9 interrupt acknowledge
    @(negedge clk);
    iack_n = 1'b0;
    idle(6);
    chk("R9 oe", {31'd0, data_oe}, 32'd1);
    chk("R9 vector", {24'd0, data_o}, {24'd0, f_vec(m_vec, 3'd5)});
    chk("R2 ack in iack", {31'd0, dack_n}, 32'd0);
    pend_src = 3'd2; pend_pri = 3'd1;
    idle(3);
    chk("R9 vector held", {24'd0, data_o}, {24'd0, f_vec(m_vec, 3'd5)});
    iack_n = 1'b1;
    idle(5);
    chk("R12 oe after iack", {31'd0, data_oe}, 32'd0);
    m_snap = f_snap(3'd6, 3'd5);
    read_chk("R9 snapshot", 6'h2B, m_snap);

    // R10 command write loads snapshot
    pend_valid = 1'b0;
    idle(2);
    chk("R11 irq high", {31'd0, irq_n}, 32'd1);
    read_chk("R11 snap after pend change", 6'h2B, m_snap);
    bus_write(6'h2A, 8'h00, 6);
    m_snap = f_snap(3'd1, 3'd2);
    read_chk("R10 command snapshot", 6'h2B, m_snap);

    // R7 fill register file, then random traffic
    for (int i = 0; i < 16; i++) begin
      d = 8'($urandom);
      bus_write(6'(i), d, 6);
      model[i] = d;
    end
    for (int i = 0; i < 16; i++) read_chk("R7 fill", 6'(i), model[i]);

    for (int it = 0; it < 80; it++) begin
      int op;
      op = $urandom % 5;
      if (op == 0) begin
        d2 = 8'($urandom % 4);
        bus_write(6'h20, d2, 1 + ($urandom % 8));
      end else if (op == 1) begin
        pend_src = 3'($urandom); pend_pri = 3'($urandom);
        bus_write(6'h2A, 8'($urandom), 1 + ($urandom % 8));
        m_snap = f_snap(pend_pri, pend_src);
        read_chk("R10 random command", 6'h2B, m_snap);
      end else if (op == 2) begin
        int idx;
        idx = $urandom % 16;
        read_chk("R7 random read", 6'(idx), model[idx]);
      end else begin
        int idx;
        idx = $urandom % 16;
        d = 8'($urandom);
        bus_write(6'(idx), d, 1 + ($urandom % 8));
        model[idx] = d;
      end
    end
    for (int i = 0; i < 16; i++) read_chk("R5 R7 final sweep", 6'(i), model[i]);
    bus_read(6'h2B, d, oe);
    chk("R9 R10 final snap", {24'd0, d}, {24'd0, m_snap});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule